// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This unit is a DSP-style arithmetic engine that sits beside an integer core. Each clock it can take one operation: two 32-bit operands (or a chosen 16-bit half of each), an opcode, an operand format and an accumulator index. It returns either a bare product or the updated value of one of several 48-bit accumulators. Three number formats are handled: signed integer, unsigned integer, and signed fixed-point fraction, where the product is doubled so the binary point stays aligned.

Every operation passes through four register stages. Stage 1 selects and extends the operands, stage 2 multiplies, stage 3 aligns the product to accumulator width, and stage 4 adds it to or subtracts it from the accumulator and presents the result. The accumulator is read in the last stage, so dependent accumulations can run back to back. Register operations load an accumulator, read it back, read the sticky overflow flags and clear a flag. Reads are taken in stage 1, so a read is held off until nothing is left in flight.

Top module: `mac_pipe`

## Requirements
- R1: An operation that produces a result (multiply, accumulate, read, flag read) drives `out_valid` high with its value on `out_data` after the third rising edge that follows the edge that accepted it. `out_valid` is low in every other cycle.
- R2: Any opcode other than read (4) and flag read (5) is always accepted (`in_ready` high), so one operation per clock can be issued.
- R3: Multiply (opcode 0) returns the low 48 bits of the full product. Format 0 treats operands as signed and format 1 as unsigned.
- R4: With `in_half` set, each operand is one 16-bit half: `in_a_hi`/`in_b_hi` = 1 picks bits 31:16, 0 picks bits 15:0. The half is sign-extended (format 0), zero-extended (format 1), or placed in bits 31:16 with zeros below (format 2).
- R5: Format 2 (fraction) returns bits 62:15 of the 64-bit signed product, which is the product doubled and taken as Q1.47. Minus one times minus one gives 0x7FFF_FFFF_FFFF.
- R6: Opcode 1 adds the aligned product to the accumulator picked by `in_acc_sel`, and opcode 2 subtracts it. The new accumulator value is the result. Back-to-back operations on the same accumulator each see the previous one's result, and other accumulators are untouched.
- R7: An accumulation whose exact result leaves the 48-bit range sets that accumulator's overflow flag. The range is two's complement for formats 0 and 2 and unsigned for format 1. Without saturation the value wraps. The flag stays set until opcode 6 clears it. Opcode 5 returns flag i in `out_data` bit i, with zeros above.
- R8: With `in_sat` set, an overflowing accumulation clamps instead of wrapping and still sets the flag. Signed results clamp to 0x7FFF_FFFF_FFFF or 0x8000_0000_0000. Unsigned results clamp to all ones on add and to zero on subtract.
- R9: Opcode 3 loads the accumulator with {`in_b[15:0]`, `in_a`} and produces no result. Opcode 4 returns the accumulator's value.
- R10: While any accepted operation is still in stages 1 to 3, a read or flag read is held off (`in_ready` low). It is accepted in the first cycle the pipeline is empty and returns the value after all earlier writes.
- R11: After reset all accumulators are zero, all flags are clear and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation accepted this cycle when high with in_valid |
| in_op | input | 3 | Opcode: 0 mul, 1 mac add, 2 mac sub, 3 load, 4 read, 5 flag read, 6 flag clear, 7 no-op |
| in_fmt | input | 2 | Format: 0 signed, 1 unsigned, 2 fraction, 3 as signed |
| in_half | input | 1 | 16x16 operation |
| in_a_hi | input | 1 | Upper half of operand A |
| in_b_hi | input | 1 | Upper half of operand B |
| in_sat | input | 1 | Saturate on accumulation overflow |
| in_acc_sel | input | 2 | Accumulator index |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| out_valid | output | 1 | Result valid |
| out_data | output | 48 | Result value |

## Verification
The hardest state to reach from the ports is a read meeting a write still in flight to the same accumulator. Only then does the issue stall matter, and a missing stall returns a stale value. The bench issues an accumulation and presents a read on the very next cycle. It counts the cycles with `in_ready` low, expecting three, and checks that the value includes the accumulation. Overflow corners are reached by first loading an accumulator to its extreme value with the load opcode, so a single small product crosses the boundary.

// File: rtl/mac_pkg.sv
// Shared opcode and format types for the multiply-accumulate pipeline.
// Assumes opcodes arrive already decoded by the host core.
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_MACA = 3'd1,
        OP_MACS = 3'd2,
        OP_LOAD = 3'd3,
        OP_READ = 3'd4,
        OP_STAT = 3'd5,
        OP_CLRF = 3'd6,
        OP_NOP  = 3'd7
    } mac_op_e;

    typedef enum logic [1:0] {
        FMT_SINT = 2'd0,
        FMT_UINT = 2'd1,
        FMT_FRAC = 2'd2,
        FMT_RSVD = 2'd3
    } mac_fmt_e;

    typedef struct packed {
        mac_op_e  op;
        mac_fmt_e fmt;
        logic     sat;
    } mac_ctl_t;

    // True for operations whose value comes from the multiplier.
    function automatic logic op_uses_product(input mac_op_e op);
        return (op == OP_MUL) || (op == OP_MACA) || (op == OP_MACS);
    endfunction

    // True for operations that must wait for an empty pipeline.
    function automatic logic op_is_read(input mac_op_e op);
        return (op == OP_READ) || (op == OP_STAT);
    endfunction

endpackage

// File: rtl/mac_operand_prep.sv
// Selects a full word or one halfword of an operand and extends it to a
// signed DATA_W+1 value. Fraction halves are placed in the upper half so the
// binary point matches a full-width fraction. Purely combinational.
module mac_operand_prep
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0]  word_i,
    input  mac_fmt_e           fmt_i,
    input  logic               half_i,
    input  logic               hi_i,
    output logic signed [DATA_W:0] ext_o
);

    logic [HALF_W-1:0] part;
    logic [DATA_W-1:0] base;

    // Pick the halfword and build the DATA_W-bit base value.
    always_comb begin
        part = hi_i ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];
        if (!half_i) begin
            base = word_i;
        end else if (fmt_i == FMT_FRAC) begin
            base = {part, {HALF_W{1'b0}}};
        end else if (fmt_i == FMT_UINT) begin
            base = {{HALF_W{1'b0}}, part};
        end else begin
            base = {{HALF_W{part[HALF_W-1]}}, part};
        end
        ext_o = {(fmt_i != FMT_UINT) & base[DATA_W-1], base};
    end

endmodule

// File: rtl/mac_multiplier.sv
// Signed multiplier for DATA_W+1-bit operands; returns the low 2*DATA_W
// bits, which hold the exact product of any pair of DATA_W-bit signed or
// unsigned values. Combinational; the caller registers the output.
module mac_multiplier #(
    parameter int DATA_W = 32,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic signed [DATA_W:0] a_i,
    input  logic signed [DATA_W:0] b_i,
    output logic [PROD_W-1:0]      prod_o
);

    logic [PROD_W-1:0] a_wide;
    logic [PROD_W-1:0] b_wide;

    // Sign-extend to product width and multiply modulo 2^PROD_W.
    always_comb begin
        a_wide = {{(PROD_W-DATA_W-1){a_i[DATA_W]}}, a_i};
        b_wide = {{(PROD_W-DATA_W-1){b_i[DATA_W]}}, b_i};
        prod_o = a_wide * b_wide;
    end

endmodule

// File: rtl/mac_align.sv
// Maps a 2*DATA_W product to accumulator width. Integer formats keep the
// low ACC_W bits. The fraction format doubles the product and keeps the top
// ACC_W bits; the single case that overflows (min times min) saturates.
module mac_align #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 48,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic [PROD_W-1:0] prod_i,
    input  logic              frac_i,
    output logic [ACC_W-1:0]  val_o
);

    logic frac_ovf;

    // Choose integer or fraction alignment.
    always_comb begin
        frac_ovf = (prod_i[PROD_W-1:PROD_W-2] == 2'b01);
        if (!frac_i) begin
            val_o = prod_i[ACC_W-1:0];
        end else if (frac_ovf) begin
            val_o = {1'b0, {(ACC_W-1){1'b1}}};
        end else begin
            val_o = prod_i[PROD_W-2 -: ACC_W];
        end
    end

endmodule

// File: rtl/mac_acc_unit.sv
// Adds or subtracts an aligned product to an accumulator value, detecting
// overflow in the signed or unsigned sense and optionally clamping.
// Combinational.
module mac_acc_unit #(
    parameter int ACC_W = 48
) (
    input  logic [ACC_W-1:0] cur_i,
    input  logic [ACC_W-1:0] val_i,
    input  logic             sub_i,
    input  logic             uns_i,
    input  logic             sat_i,
    output logic [ACC_W-1:0] res_o,
    output logic             ovf_o
);

    logic [ACC_W:0]   cur_x;
    logic [ACC_W:0]   val_x;
    logic [ACC_W:0]   wide;
    logic [ACC_W-1:0] clamp;

    // Extend by one bit, combine, and pick the clamp value.
    always_comb begin
        cur_x = {~uns_i & cur_i[ACC_W-1], cur_i};
        val_x = {~uns_i & val_i[ACC_W-1], val_i};
        wide  = sub_i ? (cur_x - val_x) : (cur_x + val_x);
        if (uns_i) begin
            ovf_o = wide[ACC_W];
            clamp = sub_i ? '0 : '1;
        end else begin
            ovf_o = wide[ACC_W] ^ wide[ACC_W-1];
            clamp = wide[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        end
        res_o = (ovf_o && sat_i) ? clamp : wide[ACC_W-1:0];
    end

endmodule

// File: rtl/mac_pipe.sv
// Four-stage multiply-accumulate pipeline with NUM_ACC accumulators.
// Stage 1 prepares operands and samples register reads, stage 2 multiplies,
// stage 3 aligns, stage 4 accumulates and drives the result. Assumes the
// host holds an operation stable while in_ready is low.
module mac_pipe
    import mac_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ACC_W   = 48,
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = $clog2(NUM_ACC),
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [1:0]        in_fmt,
    input  logic              in_half,
    input  logic              in_a_hi,
    input  logic              in_b_hi,
    input  logic              in_sat,
    input  logic [SEL_W-1:0]  in_acc_sel,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);

    mac_op_e  in_op_e;
    mac_fmt_e in_fmt_e;
    logic     take;

    logic [DATA_W-1:0]       op_word [2];
    logic                    op_hi   [2];
    logic signed [DATA_W:0]  op_ext  [2];
    logic [ACC_W-1:0]        side_word;

    logic [ACC_W-1:0]   acc_q [NUM_ACC];
    logic [NUM_ACC-1:0] ovf_q;

    logic                   s1_v, s2_v, s3_v;
    mac_ctl_t               s1_ctl, s2_ctl, s3_ctl;
    logic [SEL_W-1:0]       s1_sel, s2_sel, s3_sel;
    logic signed [DATA_W:0] s1_a, s1_b;
    logic [ACC_W-1:0]       s1_side, s2_side, s3_val;
    logic [PROD_W-1:0]      s2_prod, mult_prod;
    logic [ACC_W-1:0]       aligned;

    logic [ACC_W-1:0] acc_res;
    logic             acc_ovf;

    assign in_op_e  = mac_op_e'(in_op);
    assign in_fmt_e = mac_fmt_e'(in_fmt);
    assign in_ready = !(op_is_read(in_op_e) && (s1_v || s2_v || s3_v));
    assign take     = in_valid && in_ready;

    assign op_word[0] = in_a;
    assign op_word[1] = in_b;
    assign op_hi[0]   = in_a_hi;
    assign op_hi[1]   = in_b_hi;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_prep
            mac_operand_prep #(.DATA_W(DATA_W)) u_prep (
                .word_i (op_word[g]),
                .fmt_i  (in_fmt_e),
                .half_i (in_half),
                .hi_i   (op_hi[g]),
                .ext_o  (op_ext[g])
            );
        end
    endgenerate

    // Value carried by register operations: read data, flags or load word.
    always_comb begin
        case (in_op_e)
            OP_READ: side_word = acc_q[in_acc_sel];
            OP_STAT: side_word = {{(ACC_W-NUM_ACC){1'b0}}, ovf_q};
            OP_LOAD: side_word = {in_b[ACC_W-DATA_W-1:0], in_a};
            default: side_word = '0;
        endcase
    end

    // Stage 1: capture the accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_ctl  <= '{op: OP_NOP, fmt: FMT_SINT, sat: 1'b0};
            s1_sel  <= '0;
            s1_a    <= '0;
            s1_b    <= '0;
            s1_side <= '0;
        end else begin
            s1_v <= take;
            if (take) begin
                s1_ctl  <= '{op: in_op_e, fmt: in_fmt_e, sat: in_sat};
                s1_sel  <= in_acc_sel;
                s1_a    <= op_ext[0];
                s1_b    <= op_ext[1];
                s1_side <= side_word;
            end
        end
    end

    mac_multiplier #(.DATA_W(DATA_W)) u_mult (
        .a_i    (s1_a),
        .b_i    (s1_b),
        .prod_o (mult_prod)
    );

    // Stage 2: register the product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_ctl  <= '{op: OP_NOP, fmt: FMT_SINT, sat: 1'b0};
            s2_sel  <= '0;
            s2_prod <= '0;
            s2_side <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_ctl  <= s1_ctl;
            s2_sel  <= s1_sel;
            s2_prod <= mult_prod;
            s2_side <= s1_side;
        end
    end

    mac_align #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_align (
        .prod_i (s2_prod),
        .frac_i (s2_ctl.fmt == FMT_FRAC),
        .val_o  (aligned)
    );

    // Stage 3: register the aligned product or the register-op value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_v   <= 1'b0;
            s3_ctl <= '{op: OP_NOP, fmt: FMT_SINT, sat: 1'b0};
            s3_sel <= '0;
            s3_val <= '0;
        end else begin
            s3_v   <= s2_v;
            s3_ctl <= s2_ctl;
            s3_sel <= s2_sel;
            s3_val <= op_uses_product(s2_ctl.op) ? aligned : s2_side;
        end
    end

    mac_acc_unit #(.ACC_W(ACC_W)) u_acc (
        .cur_i (acc_q[s3_sel]),
        .val_i (s3_val),
        .sub_i (s3_ctl.op == OP_MACS),
        .uns_i (s3_ctl.fmt == FMT_UINT),
        .sat_i (s3_ctl.sat),
        .res_o (acc_res),
        .ovf_o (acc_ovf)
    );

    // Stage 4: write back accumulators, flags and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ACC; i++) begin
                acc_q[i] <= '0;
            end
            ovf_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (s3_v) begin
                case (s3_ctl.op)
                    OP_MUL, OP_READ, OP_STAT: begin
                        out_valid <= 1'b1;
                        out_data  <= s3_val;
                    end
                    OP_MACA, OP_MACS: begin
                        acc_q[s3_sel] <= acc_res;
                        out_valid     <= 1'b1;
                        out_data      <= acc_res;
                        if (acc_ovf) begin
                            ovf_q[s3_sel] <= 1'b1;
                        end
                    end
                    OP_LOAD: acc_q[s3_sel] <= s3_val;
                    OP_CLRF: ovf_q[s3_sel] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mac_pipe_checker.sv
// Port-level assertions for mac_pipe. Keeps its own record of accepted
// operations and compares the issue and result ports against it.
module mac_pipe_checker
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 48,
    localparam int HALF_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [2:0]        in_op,
    input logic [1:0]        in_fmt,
    input logic              in_half,
    input logic              in_a_hi,
    input logic              in_b_hi,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [ACC_W-1:0]  out_data
);

    logic [2:0] busy_sh;
    logic [3:0] res_sh;
    logic [3:0] minsq_sh;
    logic       accepted, is_read, has_res, min_a, min_b, minsq;
    logic [HALF_W-1:0] ha, hb;

    // Classify the presented operation.
    always_comb begin
        accepted = in_valid && in_ready;
        is_read  = (in_op == 3'd4) || (in_op == 3'd5);
        has_res  = (in_op == 3'd0) || (in_op == 3'd1) || (in_op == 3'd2) || is_read;
        ha       = in_a_hi ? in_a[DATA_W-1:HALF_W] : in_a[HALF_W-1:0];
        hb       = in_b_hi ? in_b[DATA_W-1:HALF_W] : in_b[HALF_W-1:0];
        min_a    = in_half ? (ha == {1'b1, {(HALF_W-1){1'b0}}}) : (in_a == {1'b1, {(DATA_W-1){1'b0}}});
        min_b    = in_half ? (hb == {1'b1, {(HALF_W-1){1'b0}}}) : (in_b == {1'b1, {(DATA_W-1){1'b0}}});
        minsq    = (in_op == 3'd0) && (in_fmt == 2'd2) && min_a && min_b;
    end

    // Track accepted operations through the four stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_sh  <= '0;
            res_sh   <= '0;
            minsq_sh <= '0;
        end else begin
            busy_sh  <= {busy_sh[1:0], accepted};
            res_sh   <= {res_sh[2:0], accepted && has_res};
            minsq_sh <= {minsq_sh[2:0], accepted && minsq};
        end
    end

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_read && (|busy_sh)) |-> !in_ready); // R10
    AST_WRITE_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_read) |-> in_ready); // R2
    AST_RESULT_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> res_sh[3]); // R1
    AST_RESULT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        res_sh[3] |-> out_valid); // R1
    AST_FRAC_MINSQ: assert property (@(posedge clk) disable iff (!rst_n)
        minsq_sh[3] |-> (out_data == {1'b0, {(ACC_W-1){1'b1}}})); // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R11

endmodule

bind mac_pipe mac_pipe_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac_pipe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_op     (in_op),
    .in_fmt    (in_fmt),
    .in_half   (in_half),
    .in_a_hi   (in_a_hi),
    .in_b_hi   (in_b_hi),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/mac_pipe_bench.sv
// Directed bench for mac_pipe: one task per scenario, each checking itself.
module mac_pipe_bench;
    import mac_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = 3'd7;
    logic [1:0]  in_fmt = 2'd0;
    logic        in_half = 1'b0;
    logic        in_a_hi = 1'b0;
    logic        in_b_hi = 1'b0;
    logic        in_sat = 1'b0;
    logic [1:0]  in_acc_sel = 2'd0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [47:0] out_data;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [47:0] SMAX = 48'h7FFF_FFFF_FFFF;
    localparam logic [47:0] SMIN = 48'h8000_0000_0000;

    mac_pipe u_mac_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_fmt(in_fmt), .in_half(in_half), .in_a_hi(in_a_hi),
        .in_b_hi(in_b_hi), .in_sat(in_sat), .in_acc_sel(in_acc_sel),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Low 48 bits of the integer product, from the R3 definition.
    function automatic logic [47:0] int_prod(input logic [31:0] a, input logic [31:0] b, input bit uns);
        logic [63:0] p;
        if (uns) p = {32'b0, a} * {32'b0, b};
        else     p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        return p[47:0];
    endfunction

    task automatic set_in(input mac_op_e op, input mac_fmt_e fmt, input logic half,
                          input logic ahi, input logic bhi, input logic sat,
                          input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b);
        in_valid = 1'b1; in_op = op; in_fmt = fmt; in_half = half;
        in_a_hi = ahi; in_b_hi = bhi; in_sat = sat; in_acc_sel = sel;
        in_a = a; in_b = b;
    endtask

    // Issue one operation, wait for its result slot and check it.
    task automatic run_op(input mac_op_e op, input mac_fmt_e fmt, input logic half,
                          input logic ahi, input logic bhi, input logic sat,
                          input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b,
                          input bit want, input logic [47:0] exp, input string tag);
        set_in(op, fmt, half, ahi, bhi, sat, sel, a, b);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check({tag, " valid"}, {47'b0, out_valid}, {47'b0, want});
        if (want) check(tag, out_data, exp);
    endtask

    task automatic load(input logic [1:0] sel, input logic [47:0] v, input string tag);
        run_op(OP_LOAD, FMT_SINT, 0, 0, 0, 0, sel, v[31:0], {16'b0, v[47:32]}, 0, '0, tag);
    endtask

    task automatic t_reset();
        check("R11 out_valid after reset", {47'b0, out_valid}, '0);
        run_op(OP_READ, FMT_SINT, 0, 0, 0, 0, 2'd2, '0, '0, 1, '0, "R11 acc2 reset");
        run_op(OP_STAT, FMT_SINT, 0, 0, 0, 0, 2'd0, '0, '0, 1, '0, "R11 flags reset");
    endtask

    task automatic t_int_mul();
        run_op(OP_MUL, FMT_SINT, 0, 0, 0, 0, 0, 32'hFFFF_FFFD, 32'd7, 1,
               int_prod(32'hFFFF_FFFD, 32'd7, 0), "R3 signed -3*7");
        run_op(OP_MUL, FMT_UINT, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1,
               48'hFFFE_0000_0001, "R3 unsigned max*max");
        run_op(OP_MUL, FMT_SINT, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1,
               48'd1, "R3 signed -1*-1");
    endtask

    task automatic t_half();
        run_op(OP_MUL, FMT_SINT, 1, 0, 1, 0, 0, 32'h0005_FFFE, 32'h0003_0007, 1,
               48'hFFFF_FFFF_FFFA, "R4 lo(a)*hi(b) signed");
        run_op(OP_MUL, FMT_SINT, 1, 1, 0, 0, 0, 32'h0005_FFFE, 32'h0003_0007, 1,
               48'd35, "R4 hi(a)*lo(b) signed");
        run_op(OP_MUL, FMT_UINT, 1, 0, 0, 0, 0, 32'h0005_FFFE, 32'h0003_0007, 1,
               48'h6_FFF2, "R4 lo*lo unsigned");
    endtask

    task automatic t_frac();
        run_op(OP_MUL, FMT_FRAC, 0, 0, 0, 0, 0, 32'h4000_0000, 32'h4000_0000, 1,
               48'h2000_0000_0000, "R5 0.5*0.5");
        run_op(OP_MUL, FMT_FRAC, 0, 0, 0, 0, 0, 32'h8000_0000, 32'h4000_0000, 1,
               48'hC000_0000_0000, "R5 -1*0.5");
        run_op(OP_MUL, FMT_FRAC, 0, 0, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 1,
               SMAX, "R5 -1*-1 full");
        run_op(OP_MUL, FMT_FRAC, 1, 1, 0, 0, 0, 32'h8000_1234, 32'h0000_8000, 1,
               SMAX, "R5 -1*-1 halves");
        run_op(OP_MUL, FMT_FRAC, 1, 0, 1, 0, 0, 32'h0000_4000, 32'h4000_0000, 1,
               48'h2000_0000_0000, "R5 0.5*0.5 halves");
    endtask

    // Back-to-back accumulations on two accumulators, one issue per clock.
    task automatic t_mac_stream();
        load(2'd1, '0, "R9 load acc1");
        load(2'd2, '0, "R9 load acc2");
        set_in(OP_MACA, FMT_SINT, 0, 0, 0, 0, 2'd1, 32'd2, 32'd3);
        @(negedge clk);
        set_in(OP_MACA, FMT_SINT, 0, 0, 0, 0, 2'd2, 32'd7, 32'd1);
        @(negedge clk);
        set_in(OP_MACA, FMT_SINT, 0, 0, 0, 0, 2'd1, 32'd4, 32'd5);
        @(negedge clk);
        set_in(OP_MACS, FMT_SINT, 0, 0, 0, 0, 2'd1, 32'd1, 32'd10);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 stream 1", out_data, 48'd6);
        @(negedge clk);
        check("R6 stream 2", out_data, 48'd7);
        @(negedge clk);
        check("R6 stream 3", out_data, 48'd26);
        @(negedge clk);
        check("R6 stream 4 sub", out_data, 48'd16);
        check("R1 stream valid", {47'b0, out_valid}, 48'd1);
        @(negedge clk);
        check("R1 idle after stream", {47'b0, out_valid}, '0);
        run_op(OP_READ, FMT_SINT, 0, 0, 0, 0, 2'd1, '0, '0, 1, 48'd16, "R6 read acc1");
        run_op(OP_READ, FMT_SINT, 0, 0, 0, 0, 2'd2, '0, '0, 1, 48'd7, "R6 read acc2");
    endtask

    task automatic t_load_read();
        load(2'd3, 48'h1234_89AB_CDEF, "R9 load acc3");
        run_op(OP_READ, FMT_SINT, 0, 0, 0, 0, 2'd3, '0, '0, 1, 48'h1234_89AB_CDEF, "R9 read acc3");
    endtask

    task automatic t_overflow();
        load(2'd0, SMAX, "R7 load max");
        run_op(OP_MACA, FMT_SINT, 0, 0, 0, 0, 2'd0, 32'd1, 32'd1, 1, SMIN, "R7 signed wrap");
        run_op(OP_STAT, FMT_SINT, 0, 0, 0, 0, 2'd0, '0, '0, 1, 48'h1, "R7 flag0 set");
        run_op(OP_MACA, FMT_SINT, 0, 0, 0, 0, 2'd0, 32'd0, 32'd0, 1, SMIN, "R7 add zero");
        run_op(OP_STAT, FMT_SINT, 0, 0, 0, 0, 2'd0, '0, '0, 1, 48'h1, "R7 flag0 sticky");
        run_op(OP_CLRF, FMT_SINT, 0, 0, 0, 0, 2'd0, '0, '0, 0, '0, "R7 clear flag0");
        run_op(OP_STAT, FMT_SINT, 0, 0, 0, 0, 2'd0, '0, '0, 1, 48'h0, "R7 flag0 cleared");
        load(2'd3, '0, "R7 load acc3 zero");
        run_op(OP_MACS, FMT_UINT, 0, 0, 0, 0, 2'd3, 32'd1, 32'd1, 1, 48'hFFFF_FFFF_FFFF, "R7 unsigned borrow wrap");
        run_op(OP_STAT, FMT_SINT, 0, 0, 0, 0, 2'd0, '0, '0, 1, 48'h8, "R7 flag3 set");
        run_op(OP_CLRF, FMT_SINT, 0, 0, 0, 0, 2'd3, '0, '0, 0, '0, "R7 clear flag3");
    endtask

    task automatic t_saturate();
        load(2'd0, SMAX, "R8 load max");
        run_op(OP_MACA, FMT_SINT, 0, 0, 0, 1, 2'd0, 32'd1, 32'd1, 1, SMAX, "R8 signed clamp high");
        run_op(OP_STAT, FMT_SINT, 0, 0, 0, 0, 2'd0, '0, '0, 1, 48'h1, "R8 flag on clamp");
        run_op(OP_CLRF, FMT_SINT, 0, 0, 0, 0, 2'd0, '0, '0, 0, '0, "R8 clear flag0");
        load(2'd0, SMIN, "R8 load min");
        run_op(OP_MACS, FMT_SINT, 0, 0, 0, 1, 2'd0, 32'd1, 32'd1, 1, SMIN, "R8 signed clamp low");
        load(2'd1, '0, "R8 load zero");
        run_op(OP_MACS, FMT_UINT, 0, 0, 0, 1, 2'd1, 32'd1, 32'd1, 1, 48'd0, "R8 unsigned clamp zero");
        load(2'd1, 48'hFFFF_FFFF_FFFF, "R8 load ones");
        run_op(OP_MACA, FMT_UINT, 0, 0, 0, 1, 2'd1, 32'd1, 32'd1, 1, 48'hFFFF_FFFF_FFFF, "R8 unsigned clamp ones");
    endtask

    // Read presented right behind an accumulation to the same accumulator.
    task automatic t_stall();
        int stalls;
        load(2'd2, 48'd5, "R10 load acc2");
        set_in(OP_MACA, FMT_SINT, 0, 0, 0, 0, 2'd2, 32'd1, 32'd1);
        @(negedge clk);
        set_in(OP_READ, FMT_SINT, 0, 0, 0, 0, 2'd2, '0, '0);
        stalls = 0;
        #1;
        while (!in_ready && stalls < 20) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        check("R10 stall cycles", 48'(stalls), 48'd3);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 read valid", {47'b0, out_valid}, 48'd1);
        check("R10 read after write", out_data, 48'd6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_int_mul();
        t_half();
        t_frac();
        t_mac_stream();
        t_load_read();
        t_overflow();
        t_saturate();
        t_stall();
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule